// File: doc/BRIEF.md
# USB Host Schedule Traversal Sequencer

This block decides, inside every 125 µs micro-frame, which host schedule the transaction engine works from. It also produces the memory reads that bring each schedule element on chip. At every micro-frame tick it uses the low bits of the frame number to select one slot of a periodic pointer array. It reads that slot and follows the linked periodic elements until a pointer with its terminate bit set ends the chain. Only after that does it step through a circular ring of asynchronous queue heads. The ring position is kept in a register, so a later micro-frame continues at the queue head where the previous one stopped.

Memory is reached through a simple non-posted read port with at most one read in flight. Each completion returns one word, the link pointer of the element that was read. The completion is checked before the next link is followed. Every element whose link has been fetched successfully is announced on a one-cycle dispatch output, tagged periodic or asynchronous. A completion that reports an error stops all traversal and sets a sticky error flag until it is cleared.

Top module: `usb_sched_seq`

## Requirements
- R1: On a micro-frame tick with the periodic schedule enabled, the next read address is `list_base` with bits [IDX_W+1:2] replaced by `frame_num[IDX_W-1:0]` and bits [1:0] zero.
- R2: A pointer word whose bit 0 is 0 names a periodic element. Its address (low two bits cleared) is read, and it is dispatched with `disp_async`=0 once its completion arrives. Links are followed in chain order, and a pointer with bit 0 = 1 ends the periodic chain for the micro-frame.
- R3: Within one micro-frame, no periodic dispatch follows an asynchronous dispatch.
- R4: After the queue head at address A is dispatched, the next asynchronous read and dispatch use the link word read from A, with its low two bits cleared. Every dispatched address has bits [1:0] = 0.
- R5: The ring position survives micro-frame ticks. The first asynchronous element of a micro-frame is the one that follows the last queue head dispatched earlier.
- R6: A tick abandons the current traversal. A completion that arrives in the tick cycle, or while a tick is pending, produces no dispatch, and the next read is the one described in R1.
- R7: With `per_en`=0 the periodic schedule is treated as empty. With `async_en`=0 no asynchronous read is issued, and the ring position follows `async_head`.
- R8: A completion with `rd_rsp_err`=1 sets `err_flag`. While the flag is set, no read or dispatch happens, even across ticks. `err_clr` clears the flag, and traversal restarts only at the next tick.
- R9: A new read request is never issued while an earlier read is still waiting for its completion.
- R10: During and right after reset, `rd_req`, `disp_valid` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uframe_tick | input | 1 | One-cycle pulse at each micro-frame start |
| frame_num | input | FN_W | Current frame number |
| per_en | input | 1 | Periodic schedule enable |
| async_en | input | 1 | Asynchronous schedule enable |
| list_base | input | AW | Base address of the periodic pointer array, aligned to its size |
| async_head | input | AW | Ring entry point loaded while the asynchronous schedule is disabled |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read completion strobe |
| rd_rsp_data | input | AW | Completion data (link pointer word) |
| rd_rsp_err | input | 1 | Completion error status |
| disp_valid | output | 1 | Element dispatch strobe |
| disp_addr | output | AW | Address of the dispatched element |
| disp_async | output | 1 | 1 for a queue head, 0 for a periodic element |
| err_flag | output | 1 | Sticky error flag |

## Verification
The collision that matters is a micro-frame tick landing in the same cycle as the completion of an asynchronous read. The design must then drop that element rather than dispatch it, start the new periodic walk, and keep the ring position on the element that was dropped. The memory model in the bench provokes this deliberately by raising the tick in the very cycle it returns a queue-head completion. The reference model then requires that the next micro-frame's asynchronous part begins with that same queue head. Random latencies and frame lengths also make ticks land while a read is still in flight, which exercises the pending-tick path.

// File: rtl/usb_sched_pkg.sv
package usb_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HALT = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    FK_LIST = 2'd0,
    FK_PER  = 2'd1,
    FK_ASY  = 2'd2
  } fetch_kind_e;
endpackage

// File: rtl/usb_sched_list_addr.sv
module usb_sched_list_addr #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int FN_W  = 14
) (
  input  logic [AW-1:0]   list_base,
  input  logic [FN_W-1:0] frame_num,
  output logic [AW-1:0]   entry_addr
);
  localparam int LO = IDX_W + 2;

  // window slot chosen by the low frame bits, one 32-bit word per slot
  assign entry_addr = {list_base[AW-1:LO], frame_num[IDX_W-1:0], 2'b00};
endmodule

// File: rtl/usb_sched_async_ptr.sv
module usb_sched_async_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          async_en,
  input  logic [AW-1:0] async_head,
  input  logic          adv,
  input  logic [AW-1:0] next_ptr,
  output logic [AW-1:0] cur_ptr
);
  always_ff @(posedge clk) begin
    if (rst)
      cur_ptr <= '0;
    else if (!async_en)
      cur_ptr <= {async_head[AW-1:2], 2'b00};
    else if (adv)
      cur_ptr <= {next_ptr[AW-1:2], 2'b00};
  end
endmodule

// File: rtl/usb_sched_seq.sv
module usb_sched_seq
  import usb_sched_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int FN_W  = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            uframe_tick,
  input  logic [FN_W-1:0] frame_num,
  input  logic            per_en,
  input  logic            async_en,
  input  logic [AW-1:0]   list_base,
  input  logic [AW-1:0]   async_head,
  input  logic            err_clr,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_rsp_valid,
  input  logic [AW-1:0]   rd_rsp_data,
  input  logic            rd_rsp_err,
  output logic            disp_valid,
  output logic [AW-1:0]   disp_addr,
  output logic            disp_async,
  output logic            err_flag
);
  seq_state_e  state_q, state_d;
  fetch_kind_e kind_q, kind_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] curp_q, curp_d;
  logic          req_d, disp_d, dasy_d, err_d;
  logic [AW-1:0] addr_d, daddr_d;
  logic [AW-1:0] entry_addr, ring_ptr, link_ptr;
  logic          link_term, a_adv, go_frame, go_async;

  assign link_ptr  = {rd_rsp_data[AW-1:2], 2'b00};
  assign link_term = rd_rsp_data[0];

  usb_sched_list_addr #(.AW(AW), .IDX_W(IDX_W), .FN_W(FN_W)) u_laddr (
    .list_base (list_base),
    .frame_num (frame_num),
    .entry_addr(entry_addr)
  );

  usb_sched_async_ptr #(.AW(AW)) u_aptr (
    .clk       (clk),
    .rst       (rst),
    .async_en  (async_en),
    .async_head(async_head),
    .adv       (a_adv),
    .next_ptr  (rd_rsp_data),
    .cur_ptr   (ring_ptr)
  );

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    pend_d   = pend_q;
    curp_d   = curp_q;
    req_d    = 1'b0;
    addr_d   = rd_addr;
    disp_d   = 1'b0;
    daddr_d  = disp_addr;
    dasy_d   = disp_async;
    err_d    = err_flag;
    a_adv    = 1'b0;
    go_frame = 1'b0;
    go_async = 1'b0;

    case (state_q)
      ST_IDLE: go_frame = uframe_tick;
      ST_WAIT: begin
        if (uframe_tick) pend_d = 1'b1;
        if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            state_d = ST_HALT;
            err_d   = 1'b1;
            pend_d  = 1'b0;
          end else if (pend_q || uframe_tick) begin
            pend_d   = 1'b0;
            go_frame = 1'b1;
          end else begin
            if (kind_q == FK_PER) begin
              disp_d  = 1'b1;
              daddr_d = curp_q;
              dasy_d  = 1'b0;
            end
            if (kind_q == FK_ASY) begin
              disp_d   = 1'b1;
              daddr_d  = ring_ptr;
              dasy_d   = 1'b1;
              a_adv    = 1'b1;
              go_async = 1'b1;
            end else if (link_term) begin
              go_async = 1'b1;
            end else begin
              req_d  = 1'b1;
              addr_d = link_ptr;
              kind_d = FK_PER;
              curp_d = link_ptr;
            end
          end
        end
      end
      ST_HALT: begin
        if (err_clr) begin
          err_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (go_frame) begin
      if (per_en) begin
        req_d   = 1'b1;
        addr_d  = entry_addr;
        kind_d  = FK_LIST;
        state_d = ST_WAIT;
      end else begin
        go_async = 1'b1;
      end
    end

    if (go_async) begin
      if (async_en) begin
        req_d   = 1'b1;
        addr_d  = a_adv ? link_ptr : ring_ptr;
        kind_d  = FK_ASY;
        state_d = ST_WAIT;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      kind_q     <= FK_LIST;
      pend_q     <= 1'b0;
      curp_q     <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      disp_valid <= 1'b0;
      disp_addr  <= '0;
      disp_async <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      state_q    <= state_d;
      kind_q     <= kind_d;
      pend_q     <= pend_d;
      curp_q     <= curp_d;
      rd_req     <= req_d;
      rd_addr    <= addr_d;
      disp_valid <= disp_d;
      disp_addr  <= daddr_d;
      disp_async <= dasy_d;
      err_flag   <= err_d;
    end
  end
endmodule

// File: rtl/usb_sched_seq_chk.sv
module usb_sched_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          uframe_tick,
  input logic          err_clr,
  input logic          rd_req,
  input logic          rd_rsp_valid,
  input logic          disp_valid,
  input logic [AW-1:0] disp_addr,
  input logic          disp_async,
  input logic          err_flag
);
  logic inflight_q;
  logic seen_async_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight_q   <= 1'b0;
      seen_async_q <= 1'b0;
    end else begin
      if (rd_rsp_valid) inflight_q <= 1'b0;
      if (rd_req)       inflight_q <= 1'b1;
      if (uframe_tick)
        seen_async_q <= 1'b0;
      else if (disp_valid && disp_async)
        seen_async_q <= 1'b1;
    end
  end

  assert_single_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !inflight_q);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (!rd_req && !disp_valid));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  assert_tick_drops_R6: assert property (@(posedge clk) disable iff (rst)
    uframe_tick |=> !disp_valid);

  assert_per_before_async_R3: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !disp_async) |-> !seen_async_q);

  assert_disp_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (disp_addr[1:0] == 2'b00));

  assert_disp_after_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> $past(rd_rsp_valid));
endmodule

bind usb_sched_seq usb_sched_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .uframe_tick (uframe_tick),
  .err_clr     (err_clr),
  .rd_req      (rd_req),
  .rd_rsp_valid(rd_rsp_valid),
  .disp_valid  (disp_valid),
  .disp_addr   (disp_addr),
  .disp_async  (disp_async),
  .err_flag    (err_flag)
);

// File: tb/sim_usb_sched_seq.sv
`timescale 1ns/1ps
module sim_usb_sched_seq;
  localparam int AW = 32, IDX_W = 3, FN_W = 14;
  localparam int RING = 5;
  localparam logic [31:0] ABASE = 32'd512;

  logic clk = 1'b0, rst = 1'b1;
  logic uframe_tick = 1'b0;
  logic [FN_W-1:0] frame_num = '0;
  logic per_en = 1'b0, async_en = 1'b0, err_clr = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic [AW-1:0] async_head = ABASE + 32'd8;
  logic rd_req, disp_valid, disp_async, err_flag;
  logic [AW-1:0] rd_addr, disp_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic [AW-1:0] rd_rsp_data = '0;

  always #2 clk = ~clk;

  usb_sched_seq #(.AW(AW), .IDX_W(IDX_W), .FN_W(FN_W)) u0 (.*);

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] mem [256];
  // memory model and tick source state
  bit busy = 0, inj = 0, hit = 0, tick_req = 0, nx_per = 0, nx_asy = 0;
  int cnt = 0, lat = 1, req_cnt = 0;
  logic [31:0] paddr = 0, last_addr = 0;
  // monitor state
  bit eval_on = 1, ctx_valid = 0, prev_tick = 0, expect_first = 0, cur_per = 0, cur_asy = 0;
  int cur_fn = 0;
  logic [31:0] resume;
  logic [31:0] got_a[$];
  bit got_k[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [31:0] list_slot(input int fn);
    return list_base + 32'((fn % (1 << IDX_W)) * 4);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      report();
    end
  end

  // memory model: one response per request, also owns tick/frame/enables
  always @(negedge clk) begin
    bit tick_now;
    tick_now = tick_req;
    rd_rsp_valid = 1'b0;
    rd_rsp_err = 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data = mem[paddr[9:2]];
        rd_rsp_err = inj;
        inj = 0;
        busy = 0;
        if (hit && paddr >= ABASE) begin tick_now = 1; hit = 0; end
      end else cnt--;
    end
    uframe_tick = tick_now;
    if (tick_now) begin
      frame_num = frame_num + 1'b1;
      per_en = nx_per;
      async_en = nx_asy;
      tick_req = 0;
    end
    if (rd_req && !rst) begin
      check(!busy, "R9 overlapping read", 1, 0);
      busy = 1; paddr = rd_addr; last_addr = rd_addr; cnt = lat - 1; req_cnt++;
    end
  end

  task automatic eval_frame();
    logic [31:0] p;
    logic [31:0] exp_p[$];
    bit ok;
    int n;
    if (cur_per) begin
      p = mem[list_slot(cur_fn) >> 2];
      while (!p[0]) begin
        exp_p.push_back({p[31:2], 2'b00});
        p = mem[p[9:2]];
      end
    end
    n = exp_p.size();
    ok = (got_a.size() >= n);
    for (int i = 0; i < n && ok; i++)
      if (got_k[i] != 1'b0 || got_a[i] != exp_p[i]) ok = 0;
    check(ok, "R2 periodic chain", 32'(got_a.size()), 32'(n));
    ok = 1;
    if (!cur_asy) begin
      ok = (got_a.size() == n);
      check(ok, "R7 async disabled", 32'(got_a.size()), 32'(n));
      resume = {async_head[31:2], 2'b00};
    end else begin
      for (int i = n; i < got_a.size(); i++) begin
        if (got_k[i] != 1'b1 || got_a[i] != resume) begin
          if (ok) check(0, "R3/R4/R5 async ring", got_a[i], resume);
          ok = 0;
        end
        resume = {mem[resume[9:2]][31:2], 2'b00};
      end
      if (ok) check(1, "R5 ring resume", 0, 0);
    end
    got_a.delete();
    got_k.delete();
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_tick) begin
        if (ctx_valid && eval_on) eval_frame();
        ctx_valid = 1; cur_fn = int'(frame_num); cur_per = per_en; cur_asy = async_en;
        expect_first = eval_on;
      end
      if (disp_valid) begin got_a.push_back(disp_addr); got_k.push_back(disp_async); end
      if (rd_req && expect_first) begin
        expect_first = 0;
        if (cur_per) check(rd_addr == list_slot(cur_fn), "R1 list slot", rd_addr, list_slot(cur_fn));
        else check(rd_addr >= ABASE, "R7 periodic skipped", rd_addr, ABASE);
      end
      prev_tick = uframe_tick;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_tick(input bit pe, input bit ae);
    nx_per = pe; nx_asy = ae; tick_req = 1;
    step(1);
    while (tick_req) step(1);
  endtask

  initial begin
    int r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'h1;
    for (int s = 0; s < (1 << IDX_W); s++) begin
      int len = s % 4;
      for (int k = len - 1; k >= 0; k--) begin
        int w = 16 + s * 4 + k;
        mem[w] = (k == len - 1) ? 32'h1 : (32'((w + 1) * 4) | ($urandom % 2 ? 32'h2 : 32'h0));
      end
      mem[s] = (len == 0) ? 32'h1 : (32'((16 + s * 4) * 4) | 32'h2);
    end
    for (int j = 0; j < RING; j++)
      mem[128 + j] = ABASE + 32'(((j + 1) % RING) * 4) + 32'($urandom % 2 * 2);
    resume = {async_head[31:2], 2'b00};

    step(3);
    check(rd_req == 0, "R10 rd_req in reset", 32'(rd_req), 0);
    check(disp_valid == 0, "R10 disp in reset", 32'(disp_valid), 0);
    check(err_flag == 0, "R10 err in reset", 32'(err_flag), 0);
    rst = 0;
    step(4);
    check(rd_req == 0 && req_cnt == 0, "R10 idle before tick", 32'(req_cnt), 0);

    for (int f = 0; f < 45; f++) begin
      lat = 1 + int'($urandom % 4);
      if (f % 5 == 3) hit = 1;
      do_tick(($urandom % 5) != 0, ($urandom % 6) != 0);
      step(45 + int'($urandom % 50));
    end
    do_tick(1, 1);
    step(60);

    // error path, R8
    eval_on = 0;
    lat = 2;
    do_tick(1, 1);
    step(40);
    inj = 1;
    for (int i = 0; i < 50 && !err_flag; i++) step(1);
    check(err_flag == 1, "R8 error sets flag", 32'(err_flag), 1);
    r0 = req_cnt;
    do_tick(1, 1);
    step(20);
    check(req_cnt == r0 && err_flag == 1, "R8 halted across tick", 32'(req_cnt), 32'(r0));
    err_clr = 1; step(1); err_clr = 0;
    step(1);
    check(err_flag == 0, "R8 flag cleared", 32'(err_flag), 0);
    step(10);
    check(req_cnt == r0, "R8 waits for tick", 32'(req_cnt), 32'(r0));
    do_tick(1, 1);
    step(3);
    check(req_cnt == r0 + 1 && last_addr == list_slot(int'(frame_num)), "R8 restart at R1 slot",
          last_addr, list_slot(int'(frame_num)));
    report();
  end
endmodule